// File: doc/BRIEF.md
# Paged Memory Read-With-Counter Transmit Sequencer

This block is the slave-side bit sequencer for a single-wire serial bus command that reads data memory together with a per-page counter. The master first writes a command byte and then a two-byte start address, one bit per write strobe. After that, the block answers every master read slot with one bit. It sends page data fetched from a synchronous memory read port, and after each page it sends a trailer: the page counter, a block of zero bits and an inverted CRC-16.

The memory is organised as pages of 32 bytes. Reading starts at the addressed byte, so the first page may be partial. After each trailer, the next page follows from its byte 0. After the trailer of the last page, the line stays high. A bus reset pulse abandons the sequence at any point. Slot timing, reset/presence detection and every other command path belong to neighbouring blocks.

The memory port has a latency of one cycle: the block raises `mem_rd_en` for one cycle with `mem_addr` valid, the memory returns `mem_rdata` on the next cycle, and the block loads it one cycle later. Strobes on `wr_valid` and `rd_slot` are therefore expected at least three clock cycles apart, which is far tighter than any real bit slot.

Top module: `memctr_read_seq`

## Requirements
- R1: The command byte A5h is received least significant bit first. It is followed by the start address, low byte then high byte, each least significant bit first. Only address bits 8:0 select the starting byte; bits 15:9 are ignored.
- R2: Data is sent least significant bit first, from the start byte through byte 31 of its page (offset bits 4:0 all ones), with each byte read from the memory at its own address.
- R3: After the last data bit of a page, the block sends 32 counter bits, least significant bit first. For pages 12 to 15, this is the `cnt_value` presented for the page on `cnt_page`. For pages 0 to 11, it is FFFFFFFFh.
- R4: The 32 counter bits are followed by 32 bits of logic 0.
- R5: The 32 zero bits are followed by the bitwise inverse of the CRC, least significant bit first. The CRC uses x^16+x^15+x^2+1, reflected, and is updated one bit at a time. On the first page it starts at zero and covers the command bits, all 16 address bits as received, the data bits sent, the counter and the zeros.
- R6: On every later page, the CRC restarts at zero and covers only that page's data, counter and zeros.
- R7: After a trailer, unless the page was page 15, the next page follows from its byte 0.
- R8: After the trailer of page 15, every read slot returns 1 and no memory read is issued, until a bus reset.
- R9: A `bus_rst` pulse aborts the sequence in any state. From the next cycle the output is 1, no memory read is pending, and a new command is accepted. After `rst`, the output is 1 and `mem_rd_en` is 0.
- R10: If the received command byte is not A5h, the block outputs 1, ignores all further strobes and issues no memory read until a bus reset.
- R11: `mem_rd_en` is a single-cycle pulse, and `mem_addr` only changes in a cycle where `mem_rd_en` is raised.
- R12: Read slots during command or address reception return 1 and do not advance anything. Write strobes during the read phases leave the data stream and the CRC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Bus reset pulse, aborts the sequence |
| wr_valid | input | 1 | Master write bit strobe |
| wr_bit | input | 1 | Bit value written by the master |
| rd_slot | input | 1 | Master read slot strobe, consumes the current output bit |
| tx_bit | output | 1 | Bit returned in the current read slot |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_addr | output | 9 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |
| cnt_page | output | 4 | Page whose counter is requested |
| cnt_value | input | 32 | Counter value for `cnt_page` |

## Verification
The hardest state to reach is the tail after page 15. The stimulus reaches it by starting near the end of the memory: one pass starts two bytes before the end, and another starts mid-page 13 with address bits above bit 8 set, so that it walks three pages and their trailers into the all-ones tail. The CRC restart and the first-page CRC coverage of command and address are both checked in the pass that starts at byte 31 of page 0. That pass yields a one-byte first page followed by a full second page.

// File: rtl/memctr_pkg.sv
package memctr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 32;
    localparam int PAD_W  = 32;
    localparam int CRC_W  = 16;
    localparam int BCNT_W = 5;

    localparam logic [BYTE_W-1:0] CMD_RD_CNT   = 8'hA5;
    localparam logic [CRC_W-1:0]  CRC_POLY_REV = 16'hA001;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_DATA, PH_CNT, PH_PAD, PH_CRC, PH_ONES, PH_SKIP
    } phase_e;

    // Reflected CRC-16, one bit shifted in
    function automatic logic [CRC_W-1:0] crc16_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        logic [CRC_W-1:0] r;
        fb = c[0] ^ b;
        r  = c >> 1;
        if (fb) r = r ^ CRC_POLY_REV;
        return r;
    endfunction

endpackage

// File: rtl/memctr_crc16.sv
module memctr_crc16
    import memctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);
    assign crc_nxt = crc16_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (en)
            crc_q <= crc_nxt;
    end
endmodule

// File: rtl/memctr_fetch.sv
module memctr_fetch (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic req,
    output logic rd_en,
    output logic ld
);
    // rd_en: memory samples address; ld: returned byte is taken
    always_ff @(posedge clk) begin
        if (rst || abort) begin
            rd_en <= 1'b0;
            ld    <= 1'b0;
        end else begin
            rd_en <= req;
            ld    <= rd_en;
        end
    end
endmodule

// File: rtl/memctr_read_seq.sv
module memctr_read_seq
    import memctr_pkg::*;
#(
    parameter  int PAGES      = 16,
    parameter  int PAGE_BYTES = 32,
    parameter  int CNT_PAGES  = 4,
    localparam int ADDR_W     = $clog2(PAGES * PAGE_BYTES),
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              wr_valid,
    input  logic              wr_bit,
    input  logic              rd_slot,
    output logic              tx_bit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PG_W-1:0]   cnt_page,
    input  logic [CNT_W-1:0]  cnt_value
);
    localparam logic [PG_W-1:0]   FIRST_CNT_PG = PG_W'(PAGES - CNT_PAGES);
    localparam logic [PG_W-1:0]   LAST_PG      = PG_W'(PAGES - 1);
    localparam logic [OFF_W-1:0]  LAST_OFF     = OFF_W'(PAGE_BYTES - 1);
    localparam logic [BCNT_W-1:0] END_BYTE     = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] END_ADDR     = BCNT_W'(2 * BYTE_W - 1);
    localparam logic [BCNT_W-1:0] END_CNT      = BCNT_W'(CNT_W - 1);
    localparam logic [BCNT_W-1:0] END_PAD      = BCNT_W'(PAD_W - 1);
    localparam logic [BCNT_W-1:0] END_CRC      = BCNT_W'(CRC_W - 1);

    phase_e              phase;
    logic [BCNT_W-1:0]   bcnt;
    logic [CNT_W-1:0]    sh;
    logic [ADDR_W-1:0]   addr;
    logic [ADDR_W-1:0]   areg;
    logic [BYTE_W-2:0]   creg;
    logic [CRC_W-1:0]    crc_q, crc_nxt;
    logic                crc_clr, crc_en, crc_din;
    logic                fetch_req, ld;
    logic                last_pg, page_end, has_cnt;

    assign cnt_page = addr[ADDR_W-1:OFF_W];
    assign mem_addr = addr;
    assign last_pg  = (cnt_page == LAST_PG);
    assign has_cnt  = (cnt_page >= FIRST_CNT_PG);
    assign page_end = (addr[OFF_W-1:0] == LAST_OFF);

    always_comb begin
        unique case (phase)
            PH_DATA, PH_CNT, PH_CRC: tx_bit = sh[0];
            PH_PAD:                  tx_bit = 1'b0;
            default:                 tx_bit = 1'b1;
        endcase
    end

    assign crc_din = (phase == PH_CMD || phase == PH_ADDR) ? wr_bit : tx_bit;
    assign crc_en  = (wr_valid && (phase == PH_CMD || phase == PH_ADDR))
                   || (rd_slot && !ld && (phase == PH_DATA || phase == PH_CNT || phase == PH_PAD));
    assign crc_clr = bus_rst
                   || (phase == PH_CRC && rd_slot && bcnt == END_CRC && !last_pg);

    assign fetch_req = !bus_rst && (
                         (phase == PH_ADDR && wr_valid && bcnt == END_ADDR)
                      || (phase == PH_DATA && !ld && rd_slot && bcnt == END_BYTE && !page_end)
                      || (phase == PH_CRC  && rd_slot && bcnt == END_CRC && !last_pg));

    memctr_crc16 u_crc (
        .clk     (clk),
        .rst     (rst),
        .clr     (crc_clr),
        .en      (crc_en),
        .din     (crc_din),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    memctr_fetch u_fetch (
        .clk   (clk),
        .rst   (rst),
        .abort (bus_rst),
        .req   (fetch_req),
        .rd_en (mem_rd_en),
        .ld    (ld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CMD;
            bcnt  <= '0;
            sh    <= '0;
            addr  <= '0;
            areg  <= '0;
            creg  <= '0;
        end else if (bus_rst) begin
            phase <= PH_CMD;
            bcnt  <= '0;
        end else begin
            unique case (phase)
                PH_CMD: if (wr_valid) begin
                    creg <= {wr_bit, creg[BYTE_W-2:1]};
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == END_BYTE) begin
                        bcnt  <= '0;
                        phase <= ({wr_bit, creg} == CMD_RD_CNT) ? PH_ADDR : PH_SKIP;
                    end
                end
                PH_ADDR: if (wr_valid) begin
                    if (bcnt < BCNT_W'(ADDR_W))
                        areg <= {wr_bit, areg[ADDR_W-1:1]};
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == END_ADDR) begin
                        bcnt  <= '0;
                        addr  <= areg;
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (ld) begin
                        sh <= {{(CNT_W-BYTE_W){1'b0}}, mem_rdata};
                    end else if (rd_slot) begin
                        sh   <= sh >> 1;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == END_BYTE) begin
                            bcnt <= '0;
                            if (page_end) begin
                                phase <= PH_CNT;
                                sh    <= has_cnt ? cnt_value : '1;
                            end else begin
                                addr <= addr + 1'b1;
                            end
                        end
                    end
                end
                PH_CNT: if (rd_slot) begin
                    sh   <= sh >> 1;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == END_CNT) begin
                        bcnt  <= '0;
                        phase <= PH_PAD;
                    end
                end
                PH_PAD: if (rd_slot) begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == END_PAD) begin
                        bcnt  <= '0;
                        phase <= PH_CRC;
                        sh    <= {{(CNT_W-CRC_W){1'b0}}, ~crc_nxt};
                    end
                end
                PH_CRC: if (rd_slot) begin
                    sh   <= sh >> 1;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == END_CRC) begin
                        bcnt <= '0;
                        if (last_pg) begin
                            phase <= PH_ONES;
                        end else begin
                            addr  <= addr + 1'b1;
                            phase <= PH_DATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/memctr_read_seq_chk.sv
module memctr_read_seq_chk
    import memctr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rst,
    input logic              tx_bit,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input phase_e            phase
);
    assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (phase == PH_CMD && !mem_rd_en));

    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    assert_addr_move_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> mem_rd_en);

    assert_tail_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ONES && !bus_rst) |=> (phase == PH_ONES && tx_bit && !mem_rd_en));

    assert_bad_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP && !bus_rst) |=> (phase == PH_SKIP && tx_bit && !mem_rd_en));
endmodule

bind memctr_read_seq memctr_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rst   (bus_rst),
    .tx_bit    (tx_bit),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .phase     (phase)
);

// File: tb/tb_memctr_read_seq.sv
module tb_memctr_read_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_bit = 1'b0;
    logic        rd_slot = 1'b0;
    logic        tx_bit;
    logic        mem_rd_en;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_rdata;
    logic [3:0]  cnt_page;
    logic [31:0] cnt_value;

    logic [7:0]  mem [512];
    int          total = 0;
    int          bad = 0;
    int          rd_cnt = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    memctr_read_seq dut (
        .clk       (clk),
        .rst       (rst),
        .bus_rst   (bus_rst),
        .wr_valid  (wr_valid),
        .wr_bit    (wr_bit),
        .rd_slot   (rd_slot),
        .tx_bit    (tx_bit),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .cnt_page  (cnt_page),
        .cnt_value (cnt_value)
    );

    function automatic logic [31:0] cnt_of(input logic [3:0] pg);
        return (32'h1000_0001 * ({28'd0, pg} + 32'd1)) ^ 32'h5A5A_0000;
    endfunction

    assign cnt_value = cnt_of(cnt_page);

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'hA001;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wbyte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); wr_valid = 1'b1; wr_bit = b[i];
            @(negedge clk); wr_valid = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic rbits(input int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); v[i] = tx_bit; rd_slot = 1'b1;
            @(negedge clk); rd_slot = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic pulse_bus_rst();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    // Full command, then npages pages with trailers; extra adds ignored strobes
    task automatic run_read(input logic [15:0] a16, input int npages, input bit tail, input bit extra);
        logic [15:0] crc;
        logic [8:0]  a;
        logic [31:0] v, e;
        bit          first_byte;
        pulse_bus_rst();
        if (extra) begin
            for (int k = 0; k < 3; k++) begin
                rbits(1, v);
                chk("R12 read slot before command", v, 32'h1);
            end
        end
        crc = '0;
        wbyte(8'hA5);
        for (int i = 0; i < 8; i++) crc = crc_bit(crc, 1'(8'hA5 >> i));
        wbyte(a16[7:0]);
        wbyte(a16[15:8]);
        for (int i = 0; i < 16; i++) crc = crc_bit(crc, a16[i]);
        a = a16[8:0];
        first_byte = 1;
        for (int p = 0; p < npages; p++) begin
            forever begin
                rbits(8, v);
                e = {24'd0, mem[a]};
                chk("R2 data byte", v, e);
                for (int i = 0; i < 8; i++) crc = crc_bit(crc, e[i]);
                if (extra && first_byte) begin
                    @(negedge clk); wr_valid = 1'b1; wr_bit = 1'b1;
                    @(negedge clk); wr_valid = 1'b0;
                    repeat (3) @(negedge clk);
                end
                first_byte = 0;
                if (a[4:0] == 5'd31) break;
                a = a + 1'b1;
            end
            e = (a[8:5] >= 4'd12) ? cnt_of(a[8:5]) : 32'hFFFF_FFFF;
            rbits(32, v);
            chk("R3 counter field", v, e);
            for (int i = 0; i < 32; i++) crc = crc_bit(crc, e[i]);
            rbits(32, v);
            chk("R4 zero field", v, 32'h0);
            for (int i = 0; i < 32; i++) crc = crc_bit(crc, 1'b0);
            rbits(16, v);
            chk(p == 0 ? "R5 first page crc" : "R6 later page crc", v, {16'd0, ~crc});
            if (a[8:5] == 4'd15) begin
                if (tail) begin
                    rbits(16, v);
                    chk("R8 ones after last page", v, 32'h0000_FFFF);
                end
                break;
            end
            a = a + 1'b1;
            crc = '0;
        end
    endtask

    // {start address, pages to read, check tail}
    localparam logic [24:0] VEC [6] = '{
        {16'h0000, 8'd1, 1'b0},
        {16'h001F, 8'd2, 1'b0},
        {16'hFE75, 8'd1, 1'b0},
        {16'h0185, 8'd1, 1'b0},
        {16'h01FE, 8'd1, 1'b1},
        {16'h03B0, 8'd3, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          n0;
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset tx_bit", {31'd0, tx_bit}, 32'h1);
        chk("R9 reset mem_rd_en", {31'd0, mem_rd_en}, 32'h0);

        // R1 R2 R3 R4 R5 R6 R7 R8 through the vector table
        for (int t = 0; t < 6; t++)
            run_read(VEC[t][24:9], int'(VEC[t][8:1]), VEC[t][0], 1'b0);

        // R12: ignored read slots and write strobes
        run_read(16'h0046, 1, 1'b0, 1'b1);

        // R10: unknown command
        pulse_bus_rst();
        n0 = rd_cnt;
        wbyte(8'h3C);
        rbits(8, v);
        chk("R10 ones after unknown command", v, 32'h0000_00FF);
        wbyte(8'hA5);
        wbyte(8'h00);
        wbyte(8'h00);
        rbits(16, v);
        chk("R10 strobes ignored", v, 32'h0000_FFFF);
        chk("R10 no memory reads", rd_cnt - n0, 0);

        // R9: abort in the middle of data, restart
        pulse_bus_rst();
        wbyte(8'hA5);
        wbyte(8'h40);
        wbyte(8'h00);
        rbits(5, v);
        chk("R9 partial byte before abort", v, {27'd0, mem[9'h040][4:0]});
        pulse_bus_rst();
        @(negedge clk);
        chk("R9 tx_bit after abort", {31'd0, tx_bit}, 32'h1);
        run_read(16'h0041, 1, 1'b0, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule